// File: doc/BRIEF.md
# Wake Interrupt Status and Routing Unit

This unit gathers wake events from up to four wake channels and up to three peripheral wake sources (a real-time clock, an infrared receiver and a watchdog). Channel events are latched into a status register. Software acknowledges them through a write-one-to-clear register and gates them with an enable mask. A single routing register decides two things for every source: whether its event reaches the processor as an interrupt, and whether it raises a system wake request. For each source, the wake enable sits 16 bit positions above the interrupt enable.

The outputs are one shared channel interrupt, one pass-through interrupt line per peripheral source, and a wake request. All of them are registered. Software reaches the four registers over a simple 32-bit register bus with separate read and write strobes. Read data arrives one cycle after the read strobe. To bring the unit up, software first writes zero to the enable register. It then writes the routing register with only the channel interrupt routing bits set and every wake enable clear.

Top module: `wake_route_unit`

## Requirements
- R1: After reset the status, enable and routing registers read zero, and the outputs ch_irq, per_irq and wake_req are low.
- R2: The register offsets are status 0x310, enable 0x314, clear 0x318 and routing 0x31c. bus_rdata holds the addressed register on the cycle after bus_rd is sampled high.
- R3: A high ch_evt[n] sampled on a clock edge sets status bit n (bits 0 to 3 map to channels 0 to 3). The bit stays set until it is cleared.
- R4: Writing to 0x318 clears every status bit whose data bit is 1 and leaves the other bits unchanged. The clear register reads zero.
- R5: When a channel event and a clear of the same bit fall in the same cycle, the event wins and the status bit stays set.
- R6: ch_irq goes high one cycle after any status bit is set together with its enable bit and its channel routing bit.
- R7: Routing bits 0, 1 and 2 route the RTC, IR and watchdog inputs. per_irq[k] equals per_evt[k] AND routing bit k, one cycle after per_evt is sampled.
- R8: Routing bits 8 to 11 route channels 0 to 3 to ch_irq. A channel whose routing bit is clear does not raise ch_irq.
- R9: wake_req is high one cycle after any source is active while its wake enable is set. The wake enables are routing bits 16 to 18 for the peripherals and bits 24 to 27 for the channels. The enable mask plays no part in wake_req.
- R10: Unused routing bits read zero and ignore writes, so writing all ones reads back 0x0F070F07. Enable bits 4 to 31 also read zero.
- R11: Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_evt | input | 4 | Wake channel event requests |
| per_evt | input | 3 | Peripheral wake inputs (RTC, IR, watchdog) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| ch_irq | output | 1 | Shared wake channel interrupt |
| per_irq | output | 3 | Routed peripheral interrupts |
| wake_req | output | 1 | System wake request |

## Verification
Results arrive at different depths:
- Read data and per_irq are due one edge after the strobe or input is sampled.
- The peripheral term of wake_req is also due one edge after its input is sampled.
- A register write or a channel event reaches ch_irq or the channel term of wake_req two edges later. The first edge updates the register and the second updates the output register.

When the driver issues a stimulus, it files each expectation with the exact cycle number at which it is due. The monitor compares each expectation at the falling edge of that cycle, away from the active edge. The driver holds quiet long enough that no later stimulus can disturb an expectation that is still pending.

// File: rtl/wru_pkg.sv
package wru_pkg;
  localparam int REG_W      = 32;
  localparam int CH_BASE    = 8;
  localparam int WAKE_SHIFT = 16;

  typedef struct packed {
    logic en_wr;
    logic clr_wr;
    logic rt_wr;
  } wr_strobe_t;
endpackage

// File: rtl/wru_status.sv
module wru_status
  import wru_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ch_evt,
  input  logic              en_wr,
  input  logic              clr_wr,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] sts_q,
  output logic [NUM_CH-1:0] en_q
);
  logic [NUM_CH-1:0] clr_mask;
  assign clr_mask = clr_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= (sts_q & ~clr_mask) | ch_evt;
      if (en_wr) en_q <= wdata;
    end
  end

  // R3
  evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (|ch_evt) |=> ((sts_q & $past(ch_evt)) == $past(ch_evt)));
  // R4 (R5: events excluded)
  clr_works_chk: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((sts_q & $past(wdata & ~ch_evt)) == '0));
  // R2
  en_write_chk: assert property (@(posedge clk) disable iff (rst)
    en_wr |=> (en_q == $past(wdata)));
endmodule

// File: rtl/wru_route.sv
module wru_route
  import wru_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int NUM_PERIPH = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rt_wr,
  input  logic [REG_W-1:0]      wdata,
  input  logic [NUM_CH-1:0]     sts_i,
  input  logic [NUM_CH-1:0]     en_i,
  input  logic [NUM_PERIPH-1:0] per_evt_i,
  output logic [REG_W-1:0]      route_q,
  output logic                  ch_irq,
  output logic [NUM_PERIPH-1:0] per_irq,
  output logic                  wake_req
);
  localparam logic [REG_W-1:0] PER_MASK  = REG_W'((1 << NUM_PERIPH) - 1);
  localparam logic [REG_W-1:0] CH_MASK   = REG_W'(((1 << NUM_CH) - 1) << CH_BASE);
  localparam logic [REG_W-1:0] LOW_MASK  = PER_MASK | CH_MASK;
  localparam logic [REG_W-1:0] ROUTE_MSK = LOW_MASK | (LOW_MASK << WAKE_SHIFT);

  logic [NUM_CH-1:0]     ch_ext, ch_wake;
  logic [NUM_PERIPH-1:0] per_ext, per_wake;

  assign per_ext  = route_q[0 +: NUM_PERIPH];
  assign ch_ext   = route_q[CH_BASE +: NUM_CH];
  assign per_wake = route_q[WAKE_SHIFT +: NUM_PERIPH];
  assign ch_wake  = route_q[WAKE_SHIFT + CH_BASE +: NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q  <= '0;
      ch_irq   <= 1'b0;
      per_irq  <= '0;
      wake_req <= 1'b0;
    end else begin
      if (rt_wr) route_q <= wdata & ROUTE_MSK;
      ch_irq   <= |(sts_i & en_i & ch_ext);
      per_irq  <= per_evt_i & per_ext;
      wake_req <= (|(per_evt_i & per_wake)) | (|(sts_i & ch_wake));
    end
  end

  // R6
  ch_irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    ch_irq |-> $past(|(sts_i & en_i)));
  // R9
  wake_src_chk: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> ($past(|per_evt_i) || $past(|sts_i)));
  // R7
  per_irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    ((per_irq & ~$past(per_evt_i)) == '0));
endmodule

// File: rtl/wru_regbus.sv
module wru_regbus
  import wru_pkg::*;
#(
  parameter int                NUM_CH = 4,
  parameter int                ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STS_OFF = 12'h310,
  parameter logic [ADDR_W-1:0] EN_OFF  = 12'h314,
  parameter logic [ADDR_W-1:0] CLR_OFF = 12'h318,
  parameter logic [ADDR_W-1:0] RT_OFF  = 12'h31c
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NUM_CH-1:0] sts_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [REG_W-1:0]  route_i,
  output wr_strobe_t        stb,
  output logic [REG_W-1:0]  rdata
);
  always_comb begin
    stb.en_wr  = bus_wr && (bus_addr == EN_OFF);
    stb.clr_wr = bus_wr && (bus_addr == CLR_OFF);
    stb.rt_wr  = bus_wr && (bus_addr == RT_OFF);
  end

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_addr == STS_OFF)     rd_mux = REG_W'(sts_i);
    else if (bus_addr == EN_OFF) rd_mux = REG_W'(en_i);
    else if (bus_addr == RT_OFF) rd_mux = route_i;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (bus_rd) rdata <= rd_mux;
  end

  // R4
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == CLR_OFF) |=> (rdata == '0));
endmodule

// File: rtl/wake_route_unit.sv
module wake_route_unit
  import wru_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int NUM_PERIPH = 3,
  parameter int ADDR_W     = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CH-1:0]     ch_evt,
  input  logic [NUM_PERIPH-1:0] per_evt,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [REG_W-1:0]      bus_wdata,
  output logic [REG_W-1:0]      bus_rdata,
  output logic                  ch_irq,
  output logic [NUM_PERIPH-1:0] per_irq,
  output logic                  wake_req
);
  wr_strobe_t        stb;
  logic [NUM_CH-1:0] sts, en;
  logic [REG_W-1:0]  route;

  wru_regbus #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .sts_i(sts), .en_i(en), .route_i(route),
    .stb(stb), .rdata(bus_rdata)
  );

  wru_status #(.NUM_CH(NUM_CH)) u_sts (
    .clk(clk), .rst(rst), .ch_evt(ch_evt), .en_wr(stb.en_wr),
    .clr_wr(stb.clr_wr), .wdata(bus_wdata[NUM_CH-1:0]),
    .sts_q(sts), .en_q(en)
  );

  wru_route #(.NUM_CH(NUM_CH), .NUM_PERIPH(NUM_PERIPH)) u_rt (
    .clk(clk), .rst(rst), .rt_wr(stb.rt_wr), .wdata(bus_wdata),
    .sts_i(sts), .en_i(en), .per_evt_i(per_evt), .route_q(route),
    .ch_irq(ch_irq), .per_irq(per_irq), .wake_req(wake_req)
  );
endmodule

// File: tb/sim_wake_route_unit.sv
module sim_wake_route_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ch_evt = '0;
  logic [2:0]  per_evt = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ch_irq, wake_req;
  logic [2:0]  per_irq;

  always #4 clk = ~clk;

  wake_route_unit u0 (
    .clk(clk), .rst(rst), .ch_evt(ch_evt), .per_evt(per_evt),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_irq(ch_irq),
    .per_irq(per_irq), .wake_req(wake_req)
  );

  localparam logic [11:0] A_STS = 12'h310, A_EN = 12'h314,
                          A_CLR = 12'h318, A_RT = 12'h31c;
  localparam int K_RD = 0, K_CH = 1, K_PER = 2, K_WK = 3;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    int          due;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare each expectation in its due cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        logic [31:0] act;
        case (q[i].kind)
          K_RD:    act = bus_rdata;
          K_CH:    act = {31'b0, ch_irq};
          K_PER:   act = {29'b0, per_irq};
          default: act = {31'b0, wake_req};
        endcase
        checks++;
        if (act !== q[i].exp) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", q[i].tag, q[i].kind, act, q[i].exp);
        end
        q.delete(i);
      end
    end
  end

  task automatic push(int kind, logic [31:0] exp, int dly, string tag);
    q.push_back('{kind, exp, cyc + dly, tag});
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    bus_rd = 1'b1; bus_addr = a;
    push(K_RD, exp, 1, tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    push(K_CH, 0, 1, "R1 ch_irq");
    push(K_PER, 0, 1, "R1 per_irq");
    push(K_WK, 0, 1, "R1 wake_req");
    rd(A_STS, 0, "R1 status");
    rd(A_EN, 0, "R1 enable");
    rd(A_RT, 0, "R1 routing");
    idle(2);

    // R7 peripheral interrupt routing
    wr(A_RT, 32'h0000_0007);
    per_evt = 3'b101;
    push(K_PER, 32'h5, 1, "R7 per_irq routed");
    push(K_WK, 0, 1, "R9 no wake without enable");
    idle(1); per_evt = '0; idle(2);

    // R9 peripheral wake, R7 gating
    wr(A_RT, 32'h0002_0000);
    per_evt = 3'b010;
    push(K_PER, 0, 1, "R7 per_irq gated off");
    push(K_WK, 1, 1, "R9 IR wake");
    idle(1); per_evt = '0; idle(2);

    // R10 unused bits
    wr(A_RT, 32'hFFFF_FFFF);
    rd(A_RT, 32'h0F07_0F07, "R10 routing mask");
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, 32'h0000_000F, "R10 enable mask");

    // R2 init order: enable zero then channel routing only
    wr(A_EN, 0);
    wr(A_RT, 32'h0000_0F00);
    rd(A_RT, 32'h0000_0F00, "R2 routing init");
    rd(A_EN, 0, "R2 enable init");
    idle(2);

    // R3 event latch
    ch_evt = 4'b0101;
    idle(1); ch_evt = '0;
    idle(2);
    rd(A_STS, 32'h5, "R3 status latched");
    push(K_CH, 0, 1, "R6 masked no irq");
    idle(2);

    // R6 enable
    push(K_CH, 1, 2, "R6 ch_irq enabled");
    wr(A_EN, 32'h1);
    idle(3);

    // R8 channel routing off
    push(K_CH, 0, 2, "R8 ch0 route off");
    wr(A_RT, 32'h0000_0E00);
    idle(3);
    wr(A_RT, 32'h0000_0F00);
    idle(2);

    // R11 status write ignored
    wr(A_STS, 0);
    rd(A_STS, 32'h5, "R11 status write ignored");

    // R4 clear
    push(K_CH, 0, 2, "R4 irq drops after clear");
    wr(A_CLR, 32'h1);
    rd(A_STS, 32'h4, "R4 bit0 cleared");
    rd(A_CLR, 0, "R4 clear reads zero");
    idle(2);

    // R5 event wins over clear
    ch_evt = 4'b0100;
    wr(A_CLR, 32'h4);
    ch_evt = '0;
    rd(A_STS, 32'h4, "R5 event wins");
    idle(2);

    // R9 channel wake
    push(K_WK, 1, 2, "R9 channel 2 wake");
    wr(A_RT, 32'h0400_0F00);
    idle(3);
    push(K_WK, 0, 2, "R9 wake drops after clear");
    wr(A_CLR, 32'h4);
    idle(4);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule